// File: doc/BRIEF.md
# Sector Group Lock Sequencer

This block is a host-side controller for a parallel NOR flash device. It runs the in-system algorithms that lock (protect) a sector group and unlock (unprotect) all of them. It drives the flash command bus directly: a word address, write data, one-cycle write and read strobes, and a flag that tells the board logic to raise the device reset pin to its high-voltage level. The write-protect pin is assumed to be held high outside the block. A one-cycle start pulse with a mode bit and a group number launches an operation. `busy_o` covers the whole operation. A one-cycle `done_o` or `fail_o` pulse reports the outcome.

Wait intervals are whole microseconds. An internal prescaler of `CYC_PER_US` clock cycles produces the microsecond count. A lock operation pulses only the requested group. Each pulse is followed by a verify write and a readback, and the pulse is repeated until the group reads as locked or the attempt budget is spent. An unlock operation first locks every group in ascending order, because the device requires this. It then issues a chip-wide unlock pulse and walks the groups to confirm that each one reads as unlocked. A failed check sends it back to another unlock pulse, and the walk resumes where it stopped.

Top module: `grp_lock_seq`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `busy_o`, `hv_o`, `wr_o`, `rd_o`, `done_o` and `fail_o` are all low.
- R2: `start_i` is accepted only while the block is idle. A start seen while busy has no effect on the bus or the outcome. `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` or `fail_o` pulses high for exactly one cycle, and in that cycle `busy_o` is low. `done_o` and `fail_o` are never high together.
- R3: In the cycle after an accepted start, `hv_o` rises. It is held for `HV_US*CYC_PER_US` cycles with the bus idle. Next comes one write of 0x0060 to address 0.
- R4: A lock pulse is a write of 0x0060 to an address with bits [20:12] = group, bit 6 = 0, bit 1 = 1 and all other bits 0. It is followed by `PROT_US*CYC_PER_US` cycles of idle bus.
- R5: After each wait, the verify takes three cycles. The first cycle writes 0x0040 to the same address as the pulse. The second cycle reads that address. The third cycle samples `rdata_i` to decide. For a lock check, a readback of 0x0001 passes.
- R6: The lock attempt count restarts at 1 for every group. A group gets at most `PROT_TRIES` pulses. The operation fails right after the verify of the last allowed pulse fails.
- R7: In unlock mode (`mode_i`=1), groups 0 to `NUM_GROUPS-1` are each locked in ascending order by the rules of R4 to R6 before any unlock pulse. If any of them fails, the operation fails and no unlock pulse is issued.
- R8: An unlock pulse is a write of 0x0060 to an address with bit 6 = 1, bit 1 = 1 and all other bits 0 (group field 0). It is followed by `UNPR_US*CYC_PER_US` cycles of idle bus.
- R9: The unlock walk verifies groups in ascending order at addresses with bits [20:12] = group, bit 6 = 1 and bit 1 = 1, and a readback of 0x0000 passes. A pass moves straight to the next group's verify write. A failure issues a new unlock pulse and resumes at the same group. One attempt budget of `UNPR_TRIES` pulses covers the whole walk. The operation fails when a verify fails after the last pulse.
- R10: On success, `hv_o` drops and the next cycle writes 0x00F0 to address 0. `done_o` pulses in the cycle after that. On failure, `hv_o` drops and `fail_o` pulses in the cycle after the failing decision, with no reset write.
- R11: Pulling `rst_ni` low during an operation at once drops `hv_o`, `busy_o` and both strobes. After reset is released, the block accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled only when idle |
| mode_i | input | 1 | 0 = lock one group, 1 = unlock all groups |
| grp_i | input | ADDR_W-GRP_LSB | Group number to lock in mode 0 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| hv_o | output | 1 | Request to raise the device reset pin to high voltage |
| wr_o | output | 1 | One-cycle write strobe |
| rd_o | output | 1 | One-cycle read strobe |
| addr_o | output | ADDR_W | Word address for the bus cycle |
| wdata_o | output | DATA_W | Write data |
| rdata_i | input | DATA_W | Read data, valid the cycle after `rd_o` |

## Verification
The bench uses a responder with a programmable number of pulses per group before the group locks and before it unlocks. It goes after a group that locks exactly on its last allowed attempt. If the attempt count failed to restart per group, that group would be reported as a failure. It also goes after a walk whose middle group needs extra unlock pulses. A design that restarted the walk at group 0 would issue extra verify cycles, and one that kept a separate budget per group would run past the shared attempt limit. A lock failure inside the precondition phase must end with no unlock pulse. A start during busy must leave the cycle-exact bus trace untouched.

// File: rtl/gl_pkg.sv
package gl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HV, ST_SETUP, ST_PULSE, ST_PWAIT,
    ST_VWR, ST_VRD, ST_VCHK, ST_RSTC, ST_DONE, ST_FAIL
  } gl_state_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_SETUP, OP_PULSE, OP_VWR, OP_VRD, OP_RESET
  } gl_op_e;

  localparam logic [7:0] CMD_PULSE  = 8'h60;
  localparam logic [7:0] CMD_VERIFY = 8'h40;
  localparam logic [7:0] CMD_RESET  = 8'hF0;

  // address bits decoded by the device during protect/unprotect cycles
  localparam int BIT_SEL = 6;
  localparam int BIT_ONE = 1;

endpackage

// File: rtl/gl_us_timer.sv
module gl_us_timer #(
  parameter int CYC_PER_US = 50,
  parameter int US_W       = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [US_W-1:0] us_i,
  output logic            expire_o
);

  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre_q;
  logic [US_W-1:0]  us_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (load_i) begin
      pre_q <= PRE_TOP;
      us_q  <= us_i;
    end else if (us_q != '0) begin
      if (pre_q == '0) begin
        pre_q <= PRE_TOP;
        us_q  <= us_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  // last cycle of the loaded interval
  assign expire_o = (us_q == US_W'(1)) && (pre_q == '0);

endmodule

// File: rtl/gl_bus_enc.sv
module gl_bus_enc
  import gl_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int GRP_LSB = 12,
  parameter int GRP_W   = ADDR_W - GRP_LSB
) (
  input  gl_op_e             op_i,
  input  logic [GRP_W-1:0]   grp_i,
  input  logic               unp_i,
  output logic               wr_o,
  output logic               rd_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  wdata_o
);

  logic [ADDR_W-1:0] vfy_addr;
  logic [ADDR_W-1:0] pulse_addr;

  always_comb begin
    vfy_addr                    = '0;
    vfy_addr[GRP_LSB +: GRP_W]  = grp_i;
    vfy_addr[BIT_SEL]           = unp_i;
    vfy_addr[BIT_ONE]           = 1'b1;
    pulse_addr                  = vfy_addr;
    // the chip-wide unprotect pulse carries no group
    if (unp_i) pulse_addr[GRP_LSB +: GRP_W] = '0;
  end

  always_comb begin
    wr_o    = 1'b0;
    rd_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (op_i)
      OP_SETUP: begin
        wr_o    = 1'b1;
        wdata_o = DATA_W'(CMD_PULSE);
      end
      OP_PULSE: begin
        wr_o    = 1'b1;
        addr_o  = pulse_addr;
        wdata_o = DATA_W'(CMD_PULSE);
      end
      OP_VWR: begin
        wr_o    = 1'b1;
        addr_o  = vfy_addr;
        wdata_o = DATA_W'(CMD_VERIFY);
      end
      OP_VRD: begin
        rd_o    = 1'b1;
        addr_o  = vfy_addr;
      end
      OP_RESET: begin
        wr_o    = 1'b1;
        wdata_o = DATA_W'(CMD_RESET);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gl_ctrl.sv
module gl_ctrl
  import gl_pkg::*;
#(
  parameter int GRP_W      = 9,
  parameter int NUM_GROUPS = 21,
  parameter int DATA_W     = 16,
  parameter int US_W       = 14,
  parameter int HV_US      = 1,
  parameter int PROT_US    = 150,
  parameter int UNPR_US    = 15000,
  parameter int PROT_TRIES = 25,
  parameter int UNPR_TRIES = 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [GRP_W-1:0]   grp_i,
  input  logic [DATA_W-1:0]  rdata_i,
  input  logic               expire_i,
  output logic               load_o,
  output logic [US_W-1:0]    load_us_o,
  output gl_op_e             op_o,
  output logic [GRP_W-1:0]   grp_o,
  output logic               unp_o,
  output logic               hv_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o
);

  localparam int TRY_MAX = (PROT_TRIES > UNPR_TRIES) ? PROT_TRIES : UNPR_TRIES;
  localparam int TRY_W   = $clog2(TRY_MAX + 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NUM_GROUPS - 1);

  gl_state_e          st_q, st_d;
  logic               mode_q, mode_d;
  logic               unp_q, unp_d;
  logic [GRP_W-1:0]   grp_q, grp_d;
  logic [TRY_W-1:0]   try_q, try_d;

  logic pass, grp_last, prot_spent, unpr_spent;

  assign pass       = (rdata_i == (unp_q ? DATA_W'(0) : DATA_W'(1)));
  assign grp_last   = (grp_q == GRP_LAST);
  assign prot_spent = (try_q == TRY_W'(PROT_TRIES));
  assign unpr_spent = (try_q == TRY_W'(UNPR_TRIES));

  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    unp_d     = unp_q;
    grp_d     = grp_q;
    try_d     = try_q;
    load_o    = 1'b0;
    load_us_o = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d      = ST_HV;
        mode_d    = mode_i;
        unp_d     = 1'b0;
        grp_d     = mode_i ? '0 : grp_i;
        try_d     = TRY_W'(1);
        load_o    = 1'b1;
        load_us_o = US_W'(HV_US);
      end
      ST_HV:    if (expire_i) st_d = ST_SETUP;
      ST_SETUP: st_d = ST_PULSE;
      ST_PULSE: begin
        st_d      = ST_PWAIT;
        load_o    = 1'b1;
        load_us_o = unp_q ? US_W'(UNPR_US) : US_W'(PROT_US);
      end
      ST_PWAIT: if (expire_i) st_d = ST_VWR;
      ST_VWR:   st_d = ST_VRD;
      ST_VRD:   st_d = ST_VCHK;
      ST_VCHK: begin
        if (!unp_q) begin
          if (pass) begin
            try_d = TRY_W'(1);
            if (!mode_q) begin
              st_d = ST_RSTC;
            end else if (grp_last) begin
              // precondition met: switch to the unprotect phase
              st_d  = ST_PULSE;
              unp_d = 1'b1;
              grp_d = '0;
            end else begin
              st_d  = ST_PULSE;
              grp_d = grp_q + 1'b1;
            end
          end else if (prot_spent) begin
            st_d = ST_FAIL;
          end else begin
            st_d  = ST_PULSE;
            try_d = try_q + 1'b1;
          end
        end else begin
          if (pass) begin
            if (grp_last) st_d = ST_RSTC;
            else begin
              st_d  = ST_VWR;
              grp_d = grp_q + 1'b1;
            end
          end else if (unpr_spent) begin
            st_d = ST_FAIL;
          end else begin
            st_d  = ST_PULSE;
            try_d = try_q + 1'b1;
          end
        end
      end
      ST_RSTC: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      ST_FAIL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      unp_q  <= 1'b0;
      grp_q  <= '0;
      try_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      unp_q  <= unp_d;
      grp_q  <= grp_d;
      try_q  <= try_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_SETUP: op_o = OP_SETUP;
      ST_PULSE: op_o = OP_PULSE;
      ST_VWR:   op_o = OP_VWR;
      ST_VRD:   op_o = OP_VRD;
      ST_RSTC:  op_o = OP_RESET;
      default:  op_o = OP_NONE;
    endcase
  end

  assign grp_o  = grp_q;
  assign unp_o  = unp_q;
  assign hv_o   = (st_q inside {ST_HV, ST_SETUP, ST_PULSE, ST_PWAIT,
                                ST_VWR, ST_VRD, ST_VCHK});
  assign busy_o = !(st_q inside {ST_IDLE, ST_DONE, ST_FAIL});
  assign done_o = (st_q == ST_DONE);
  assign fail_o = (st_q == ST_FAIL);

endmodule

// File: rtl/grp_lock_seq.sv
module grp_lock_seq
  import gl_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 16,
  parameter int GRP_LSB    = 12,
  parameter int NUM_GROUPS = 21,
  parameter int CYC_PER_US = 50,
  parameter int HV_US      = 1,
  parameter int PROT_US    = 150,
  parameter int UNPR_US    = 15000,
  parameter int PROT_TRIES = 25,
  parameter int UNPR_TRIES = 1000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       mode_i,
  input  logic [ADDR_W-GRP_LSB-1:0]  grp_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       fail_o,
  output logic                       hv_o,
  output logic                       wr_o,
  output logic                       rd_o,
  output logic [ADDR_W-1:0]          addr_o,
  output logic [DATA_W-1:0]          wdata_o,
  input  logic [DATA_W-1:0]          rdata_i
);

  localparam int GRP_W  = ADDR_W - GRP_LSB;
  localparam int US_MX1 = (PROT_US > UNPR_US) ? PROT_US : UNPR_US;
  localparam int US_MAX = (US_MX1 > HV_US) ? US_MX1 : HV_US;
  localparam int US_W   = $clog2(US_MAX + 1);

  logic              load;
  logic [US_W-1:0]   load_us;
  logic              expire;
  gl_op_e            op;
  logic [GRP_W-1:0]  grp;
  logic              unp;

  gl_us_timer #(
    .CYC_PER_US (CYC_PER_US),
    .US_W       (US_W)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .us_i     (load_us),
    .expire_o (expire)
  );

  gl_ctrl #(
    .GRP_W      (GRP_W),
    .NUM_GROUPS (NUM_GROUPS),
    .DATA_W     (DATA_W),
    .US_W       (US_W),
    .HV_US      (HV_US),
    .PROT_US    (PROT_US),
    .UNPR_US    (UNPR_US),
    .PROT_TRIES (PROT_TRIES),
    .UNPR_TRIES (UNPR_TRIES)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .grp_i     (grp_i),
    .rdata_i   (rdata_i),
    .expire_i  (expire),
    .load_o    (load),
    .load_us_o (load_us),
    .op_o      (op),
    .grp_o     (grp),
    .unp_o     (unp),
    .hv_o      (hv_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fail_o    (fail_o)
  );

  gl_bus_enc #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .GRP_LSB (GRP_LSB),
    .GRP_W   (GRP_W)
  ) i_bus (
    .op_i    (op),
    .grp_i   (grp),
    .unp_i   (unp),
    .wr_o    (wr_o),
    .rd_o    (rd_o),
    .addr_o  (addr_o),
    .wdata_o (wdata_o)
  );

endmodule

// File: rtl/grp_lock_seq_chk.sv
module grp_lock_seq_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              hv_o,
  input logic              wr_o,
  input logic              rd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o
);

  assert_done_fail_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_done_ends_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_fail_ends_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!busy_o && $past(busy_o)));

  assert_busy_needs_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_hv_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_o |-> busy_o);

  assert_no_rd_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && rd_o));

  assert_pulse_then_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && addr_o[1] && wdata_o[7:0] == 8'h60) |=> (!wr_o && !rd_o));

  assert_rd_under_hv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> hv_o);

  assert_reset_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !hv_o) |-> (wdata_o[7:0] == 8'hF0 && $past(hv_o)));

  assert_reset_then_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && !hv_o) |=> done_o);

endmodule

bind grp_lock_seq grp_lock_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .fail_o  (fail_o),
  .hv_o    (hv_o),
  .wr_o    (wr_o),
  .rd_o    (rd_o),
  .addr_o  (addr_o),
  .wdata_o (wdata_o)
);

// File: tb/test_grp_lock_seq.sv
module test_grp_lock_seq;

  localparam int AW = 21, DW = 16, GL = 12, NG = 4;
  localparam int CPU = 2, HVU = 1, PWU = 3, UWU = 4, PT = 3, UT = 5;
  localparam int HC = HVU * CPU, PC = PWU * CPU, UC = UWU * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start_i = 1'b0, mode_i = 1'b0;
  logic [8:0]    grp_i = '0;
  logic          busy_o, done_o, fail_o, hv_o, wr_o, rd_o;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] wdata_o;
  logic [DW-1:0] rdata_r = '0;

  grp_lock_seq #(
    .ADDR_W(AW), .DATA_W(DW), .GRP_LSB(GL), .NUM_GROUPS(NG), .CYC_PER_US(CPU),
    .HV_US(HVU), .PROT_US(PWU), .UNPR_US(UWU), .PROT_TRIES(PT), .UNPR_TRIES(UT)
  ) i_grp_lock_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i), .grp_i(grp_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .hv_o(hv_o), .wr_o(wr_o),
    .rd_o(rd_o), .addr_o(addr_o), .wdata_o(wdata_o), .rdata_i(rdata_r)
  );

  // ---------------- flash responder ----------------
  int  need_p[NG], need_u[NG], hits[NG];
  bit  prot[NG];
  int  uhits;
  bit  unp_seen, all_prot_at_unp, resp_clr;

  always @(posedge clk) begin
    int gi;
    gi = int'(addr_o[GL +: 9]);
    if (resp_clr) begin
      for (int i = 0; i < NG; i++) begin hits[i] = 0; prot[i] = 1'b0; end
      uhits = 0; unp_seen = 1'b0; all_prot_at_unp = 1'b0;
    end else begin
      if (wr_o && wdata_o == 16'h0060 && addr_o[1] && !addr_o[0]) begin
        if (!addr_o[6]) begin
          if (gi < NG) begin
            hits[gi] = hits[gi] + 1;
            if (hits[gi] >= need_p[gi]) prot[gi] = 1'b1;
          end
        end else begin
          uhits = uhits + 1;
          if (!unp_seen) begin
            unp_seen = 1'b1;
            all_prot_at_unp = 1'b1;
            for (int i = 0; i < NG; i++) if (!prot[i]) all_prot_at_unp = 1'b0;
          end
          for (int i = 0; i < NG; i++) if (uhits >= need_u[i]) prot[i] = 1'b0;
        end
      end
      if (rd_o) rdata_r <= (gi < NG && prot[gi]) ? 16'h0001 : 16'h0000;
    end
  end

  // ---------------- reference model ----------------
  typedef struct packed {
    logic b, h, w, r, d, f;
    logic [AW-1:0] a;
    logic [DW-1:0] x;
  } cyc_t;

  cyc_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0, cyc = 0, done_cnt = 0, fail_cnt = 0;

  function automatic logic [AW-1:0] pa(int g, bit unp);
    logic [AW-1:0] v;
    v = '0;
    v[GL +: 9] = g[8:0];
    v[6] = unp;
    v[1] = 1'b1;
    return v;
  endfunction

  function automatic void push(logic b, logic h, logic w, logic r, logic d, logic f,
                               logic [AW-1:0] a, logic [DW-1:0] x, string t, int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(cyc_t'{b, h, w, r, d, f, a, x});
      tag_q.push_back(t);
    end
  endfunction

  function automatic bit gen_prot(int g);
    for (int t = 1; t <= PT; t++) begin
      push(1, 1, 1, 0, 0, 0, pa(g, 0), 16'h0060, "R4", 1);
      push(1, 1, 0, 0, 0, 0, '0, '0, "R4", PC);
      push(1, 1, 1, 0, 0, 0, pa(g, 0), 16'h0040, "R5", 1);
      push(1, 1, 0, 1, 0, 0, pa(g, 0), '0, "R5", 1);
      push(1, 1, 0, 0, 0, 0, '0, '0, "R6", 1);
      if (t >= need_p[g]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit gen_unp();
    int u = 0, s = 0, t = 1;
    forever begin
      push(1, 1, 1, 0, 0, 0, pa(0, 1), 16'h0060, "R8", 1);
      u++;
      push(1, 1, 0, 0, 0, 0, '0, '0, "R8", UC);
      forever begin
        push(1, 1, 1, 0, 0, 0, pa(s, 1), 16'h0040, "R9", 1);
        push(1, 1, 0, 1, 0, 0, pa(s, 1), '0, "R9", 1);
        push(1, 1, 0, 0, 0, 0, '0, '0, "R9", 1);
        if (u >= need_u[s]) begin
          if (s == NG - 1) return 1'b1;
          s++;
        end else begin
          if (t == UT) return 1'b0;
          t++;
          break;
        end
      end
    end
    return 1'b0;
  endfunction

  function automatic void gen(bit m, int g);
    bit ok;
    push(1, 1, 0, 0, 0, 0, '0, '0, "R3", HC);
    push(1, 1, 1, 0, 0, 0, '0, 16'h0060, "R3", 1);
    if (!m) ok = gen_prot(g);
    else begin
      ok = 1'b1;
      for (int gg = 0; gg < NG; gg++) if (ok) ok = gen_prot(gg);
      if (ok) ok = gen_unp();
    end
    if (ok) begin
      push(1, 0, 1, 0, 0, 0, '0, 16'h00F0, "R10", 1);
      push(0, 0, 0, 0, 1, 0, '0, '0, "R10", 1);
    end else begin
      push(0, 0, 0, 0, 0, 1, '0, '0, "R10", 1);
    end
  endfunction

  // ---------------- checking ----------------
  task automatic cmp();
    cyc_t e, a;
    string t;
    if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
    else begin e = '0; t = "R2"; end
    a = cyc_t'{busy_o, hv_o, wr_o, rd_o, done_o, fail_o, addr_o, wdata_o};
    if (!(e.w || e.r)) begin a.a = '0; e.a = '0; end
    if (!e.w) begin a.x = '0; e.x = '0; end
    if (done_o) done_cnt++;
    if (fail_o) fail_cnt++;
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", t, cyc, a, e);
    end
  endtask

  task automatic chk(bit ok, string t, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    cmp();
  endtask

  task automatic set_need(int p0, int p1, int p2, int p3, int u0, int u1, int u2, int u3);
    need_p[0] = p0; need_p[1] = p1; need_p[2] = p2; need_p[3] = p3;
    need_u[0] = u0; need_u[1] = u1; need_u[2] = u2; need_u[3] = u3;
  endtask

  task automatic run(bit m, int g, int inj);
    int k = 0;
    resp_clr = 1'b1; step(); resp_clr = 1'b0;
    gen(m, g);
    mode_i = m; grp_i = g[8:0]; start_i = 1'b1;
    step();
    start_i = 1'b0;
    while (exp_q.size() > 0) begin
      if (k == inj) begin start_i = 1'b1; mode_i = ~m; grp_i = 9'd0; end
      step();
      start_i = 1'b0;
      k++;
    end
    repeat (2) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, f0;
    resp_clr = 1'b1;
    set_need(1, 1, 1, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy_o && !hv_o && !wr_o && !rd_o && !done_o && !fail_o, "R1", "outputs in reset",
        {busy_o, hv_o, wr_o, rd_o, done_o, fail_o}, 0);
    rst_n = 1'b1;
    step();
    chk(!busy_o && !hv_o && !wr_o && !rd_o, "R1", "outputs after reset", busy_o, 0);

    // R4 R5: lock group 2 on first try; stray start mid-run must be ignored (R2)
    d0 = done_cnt;
    run(1'b0, 2, 5);
    chk(done_cnt == d0 + 1, "R2", "done after ignored start", done_cnt - d0, 1);
    chk(hits[2] == 1 && hits[0] == 0, "R2", "pulses to group 2 only", hits[2], 1);

    // R6: lock on last allowed attempt
    set_need(1, 1, 1, PT, 1, 1, 1, 1);
    d0 = done_cnt;
    run(1'b0, 3, -1);
    chk(hits[3] == PT, "R6", "pulses on boundary group", hits[3], PT);
    chk(done_cnt == d0 + 1, "R6", "boundary group done", done_cnt - d0, 1);

    // R6: lock fails after budget
    set_need(1, PT + 1, 1, 1, 1, 1, 1, 1);
    f0 = fail_cnt;
    run(1'b0, 1, -1);
    chk(hits[1] == PT, "R6", "pulses before lock failure", hits[1], PT);
    chk(fail_cnt == f0 + 1, "R10", "fail pulse on lock failure", fail_cnt - f0, 1);

    // R7 R9: unlock with per-group retry restart and a stubborn middle group
    set_need(1, 2, PT, 1, 1, 1, 3, 1);
    d0 = done_cnt;
    run(1'b1, 0, -1);
    chk(all_prot_at_unp, "R7", "all groups locked before unlock pulse", all_prot_at_unp, 1);
    chk(hits[2] == PT && hits[1] == 2, "R7", "precondition pulses group 2", hits[2], PT);
    chk(uhits == 3, "R9", "unlock pulses with resumed walk", uhits, 3);
    chk(done_cnt == d0 + 1, "R10", "unlock done", done_cnt - d0, 1);

    // R9: shared budget exhausted
    set_need(1, 1, 1, 1, 1, UT + 1, 1, 1);
    f0 = fail_cnt;
    run(1'b1, 0, -1);
    chk(uhits == UT, "R9", "unlock pulses at budget", uhits, UT);
    chk(fail_cnt == f0 + 1, "R9", "unlock failure reported", fail_cnt - f0, 1);

    // R7: precondition failure, no unlock pulse
    set_need(1, 1, PT + 1, 1, 1, 1, 1, 1);
    f0 = fail_cnt;
    run(1'b1, 0, -1);
    chk(!unp_seen, "R7", "no unlock pulse after precondition failure", unp_seen, 0);
    chk(fail_cnt == f0 + 1, "R7", "precondition failure reported", fail_cnt - f0, 1);

    // R11: asynchronous reset mid-run
    set_need(1, 1, 1, 1, 1, 1, 1, 1);
    resp_clr = 1'b1; step(); resp_clr = 1'b0;
    gen(1'b1, 0);
    mode_i = 1'b1; start_i = 1'b1; step(); start_i = 1'b0;
    repeat (12) step();
    rst_n = 1'b0;
    #1;
    chk(!busy_o && !hv_o && !wr_o && !rd_o, "R11", "outputs after mid-run reset",
        {busy_o, hv_o, wr_o, rd_o}, 0);
    exp_q.delete(); tag_q.delete();
    step();
    rst_n = 1'b1;
    step();
    d0 = done_cnt;
    run(1'b0, 0, -1);
    chk(done_cnt == d0 + 1, "R11", "operation after reset release", done_cnt - d0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule